// File: doc/BRIEF.md
# Charge-Domain Adding Unit Phase Sequencer

This block is the digital controller for one 4-bit adding cell whose arithmetic happens as charge on capacitors. It receives two operands, asks the analog side to calibrate, and clears both working capacitors. It then has a time-based DAC pour the first operand, the second operand and, if a carry-in pulse was caught, one extra unit into the primary capacitor. When the comparator spikes during these writes, the sequencer treats it as an overflow. It emits one carry-out pulse, empties the primary capacitor and steers all further charge to the secondary capacitor. A copy phase folds the secondary charge back into the primary. A counting readback then charges the secondary capacitor one LSB at a time until the comparator reports that it has passed the primary, and the number of quiet steps is the sum.

Operands enter on a valid/ready stream. `op_ready` is high only while the unit is idle, and an operand pair is taken on a cycle with `op_valid` and `op_ready` both high. Results leave on a valid/ready stream. While `sum_valid` is high and `sum_ready` is low, the result fields hold still. No new operand is taken until the result has been taken, so back-pressure on the output stalls the input. The calibration, DAC and copy links are request/acknowledge handshakes. The switch and comparator controls are plain levels and pulses.

Top module: `addcell_seq`

## Requirements
- R1: `op_ready` is high only in the idle state. After an operand pair is accepted it stays low until the result has been taken.
- R2: Each addition follows this order: `cal_req` until `cal_done`, then one cycle with `dis_a` and `dis_b` both high, then the DAC writes, then copy, then read.
- R3: `dac_req` stays high with a stable `dac_code` until `dac_ack`. The codes written are the first operand, then the second operand, then the value 1 for a carry-in.
- R4: A `cin_pulse` is held until the carry decision, which is made in the cycle the second write is acknowledged. A pulse that arrives after that decision, for example during copy, is used by the next addition.
- R5: When no carry-in is held at the decision, the carry write is skipped, so exactly two DAC writes occur.
- R6: A `cmp_spike` during a write phase, with no earlier overflow in the same addition, gives a one-cycle `cout_pulse` and a one-cycle `dis_a` in the next cycle. From that cycle `steer_b` is high until the next addition.
- R7: At most one `cout_pulse` occurs per addition. Later spikes in the write phases are ignored.
- R8: Copy holds `copy_req` until `copy_ack`, then pulses `dis_b` for one cycle before the read starts.
- R9: `cmp_sel` is 0 (reference capacitor) whenever `dac_req` is high, and 1 (secondary capacitor) whenever `lsb_step` is high.
- R10: The read pulses `lsb_step` for one cycle and samples `cmp_spike` in the following cycle. `sum_data` is the number of steps that drew no spike.
- R11: If 16 steps pass with no spike, the read ends with `sum_data` saturated at 15 and `sum_err` set to 1.
- R12: `sum_valid` with `sum_ready` low keeps `sum_valid`, `sum_data`, `sum_cout` and `sum_err` unchanged on the next cycle. `sum_cout` is 1 exactly when an overflow occurred.
- R13: With a faithful capacitor model, every one of the 512 combinations of operands and carry-in gives `sum_data` = (a+b+cin) mod 16 and `sum_cout` = (a+b+cin ≥ 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand pair valid |
| op_ready | output | 1 | Unit idle, operand pair taken |
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| cin_pulse | input | 1 | Carry-in pulse from the neighbouring unit |
| sum_valid | output | 1 | Result valid |
| sum_ready | input | 1 | Result consumer ready |
| sum_data | output | 4 | Counted sum |
| sum_cout | output | 1 | Overflow occurred in this addition |
| sum_err | output | 1 | Read ran out of steps with no spike |
| cout_pulse | output | 1 | One-cycle carry-out pulse |
| cal_req | output | 1 | Calibration request |
| cal_done | input | 1 | Calibration finished |
| dac_req | output | 1 | Time DAC write request |
| dac_ack | input | 1 | Time DAC write finished |
| dac_code | output | 4 | Value for the DAC to write |
| steer_b | output | 1 | Route DAC charge to the secondary capacitor |
| dis_a | output | 1 | Discharge primary capacitor |
| dis_b | output | 1 | Discharge secondary capacitor |
| copy_req | output | 1 | Transfer secondary charge into primary |
| copy_ack | input | 1 | Transfer finished |
| cmp_sel | output | 1 | Comparator negative input: 0 reference, 1 secondary |
| lsb_step | output | 1 | Add one LSB to the secondary capacitor |
| cmp_spike | input | 1 | Comparator firing pulse |

## Verification
Two events can meet in the same clock cycle: the comparator's overflow spike, which raises the carry-out and redirects charge, and a carry-in pulse from the neighbour, which must be captured. The bench's capacitor model fires `cin_pulse` in the very cycle it raises `cmp_spike` during an overflowing write. A correct unit must record both events: the sum must include the carry-in, and exactly one carry-out pulse must appear. A late carry-in, injected during copy, must fall through to the next addition.

// File: rtl/as_seq_pkg.sv
package as_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CAL, S_CLR, S_WR_A, S_WR_B, S_CARRY,
    S_COPY, S_CLR_B, S_RD_STEP, S_RD_WAIT, S_DONE
  } seq_state_t;
endpackage

// File: rtl/as_cin_catch.sv
module as_cin_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic cin_pulse,
  input  logic take,
  output logic have
);
  logic held_q;

  // A pulse in the decision cycle itself still counts for this addition.
  assign have = held_q | cin_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (take)   held_q <= 1'b0;
    else if (cin_pulse) held_q <= 1'b1;
  end

  // R4
  cin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_pulse && !take) |=> have);
endmodule

// File: rtl/as_ovf_track.sv
module as_ovf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic window,
  input  logic spike,
  output logic ovf,
  output logic cout_pulse,
  output logic dis_pulse
);
  logic fire;
  assign fire = window && spike && !ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf        <= 1'b0;
      cout_pulse <= 1'b0;
      dis_pulse  <= 1'b0;
    end else begin
      cout_pulse <= fire;
      dis_pulse  <= fire;
      if (arm)       ovf <= 1'b0;
      else if (fire) ovf <= 1'b1;
    end
  end

  // R7
  one_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cout_pulse |-> $rose(ovf));
  // R6
  steer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !arm) |=> ovf);
endmodule

// File: rtl/as_read_count.sv
module as_read_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         last
);
  localparam logic [W-1:0] CMAX  = '1;
  localparam int           LIMIT = 1 << W;

  logic [W:0] steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      steps <= '0;
    end else if (clr) begin
      count <= '0;
      steps <= '0;
    end else if (tick) begin
      steps <= steps + 1'b1;
      if (count != CMAX) count <= count + 1'b1;
    end
  end

  assign last = (steps == (W+1)'(LIMIT - 1));

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && count == CMAX) |=> count == CMAX);
endmodule

// File: rtl/addcell_seq.sv
module addcell_seq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin_pulse,
  output logic         sum_valid,
  input  logic         sum_ready,
  output logic [W-1:0] sum_data,
  output logic         sum_cout,
  output logic         sum_err,
  output logic         cout_pulse,
  output logic         cal_req,
  input  logic         cal_done,
  output logic         dac_req,
  input  logic         dac_ack,
  output logic [W-1:0] dac_code,
  output logic         steer_b,
  output logic         dis_a,
  output logic         dis_b,
  output logic         copy_req,
  input  logic         copy_ack,
  output logic         cmp_sel,
  output logic         lsb_step,
  input  logic         cmp_spike
);
  import as_seq_pkg::*;

  localparam logic [W-1:0] ONE_UNIT = W'(1);

  seq_state_t st, st_nx;
  logic [W-1:0] a_q, b_q;
  logic err_q;
  logic accept, cin_take, cin_have, ovf_dis, rd_tick, rd_last;

  assign accept   = (st == S_IDLE) && op_valid;
  assign cin_take = (st == S_WR_B) && dac_ack;
  assign rd_tick  = (st == S_RD_WAIT) && !cmp_spike;

  as_cin_catch u_cin (
    .clk(clk), .rst_n(rst_n), .cin_pulse(cin_pulse),
    .take(cin_take), .have(cin_have)
  );

  as_ovf_track u_ovf (
    .clk(clk), .rst_n(rst_n), .arm(accept),
    .window(st == S_WR_A || st == S_WR_B || st == S_CARRY),
    .spike(cmp_spike), .ovf(steer_b), .cout_pulse(cout_pulse),
    .dis_pulse(ovf_dis)
  );

  as_read_count #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(rd_tick),
    .count(sum_data), .last(rd_last)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:    if (op_valid) st_nx = S_CAL;
      S_CAL:     if (cal_done) st_nx = S_CLR;
      S_CLR:     st_nx = S_WR_A;
      S_WR_A:    if (dac_ack) st_nx = S_WR_B;
      S_WR_B:    if (dac_ack) st_nx = cin_have ? S_CARRY : S_COPY;
      S_CARRY:   if (dac_ack) st_nx = S_COPY;
      S_COPY:    if (copy_ack) st_nx = S_CLR_B;
      S_CLR_B:   st_nx = S_RD_STEP;
      S_RD_STEP: st_nx = S_RD_WAIT;
      S_RD_WAIT: if (cmp_spike || rd_last) st_nx = S_DONE;
                 else st_nx = S_RD_STEP;
      S_DONE:    if (sum_ready) st_nx = S_IDLE;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      err_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        a_q   <= op_a;
        b_q   <= op_b;
        err_q <= 1'b0;
      end else if (st == S_RD_WAIT && !cmp_spike && rd_last) begin
        err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st)
      S_WR_A:  dac_code = a_q;
      S_WR_B:  dac_code = b_q;
      S_CARRY: dac_code = ONE_UNIT;
      default: dac_code = '0;
    endcase
  end

  assign op_ready  = (st == S_IDLE);
  assign cal_req   = (st == S_CAL);
  assign dac_req   = (st == S_WR_A) || (st == S_WR_B) || (st == S_CARRY);
  assign dis_a     = (st == S_CLR) || ovf_dis;
  assign dis_b     = (st == S_CLR) || (st == S_CLR_B);
  assign copy_req  = (st == S_COPY);
  assign cmp_sel   = (st == S_RD_STEP) || (st == S_RD_WAIT);
  assign lsb_step  = (st == S_RD_STEP);
  assign sum_valid = (st == S_DONE);
  assign sum_cout  = steer_b;
  assign sum_err   = err_q;

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_req && !dac_ack) |=> (dac_req && $stable(dac_code)));
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_valid && !sum_ready) |=>
      (sum_valid && $stable(sum_data) && $stable(sum_cout) && $stable(sum_err)));
  // R9
  sel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_step |-> cmp_sel);
  // R9
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_req |-> !cmp_sel);
  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> !op_ready);
  // R7
  no_cout_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_step |-> !cout_pulse);
endmodule

// File: tb/test_addcell_seq.sv
module test_addcell_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [3:0] op_a = '0, op_b = '0;
  logic cin_pulse = 1'b0;
  logic sum_valid, sum_ready = 1'b0;
  logic [3:0] sum_data;
  logic sum_cout, sum_err, cout_pulse, cal_req, cal_done = 1'b0;
  logic dac_req, dac_ack = 1'b0;
  logic [3:0] dac_code;
  logic steer_b, dis_a, dis_b, copy_req, copy_ack = 1'b0, cmp_sel, lsb_step;
  logic cmp_spike = 1'b0;

  always #2.5 clk = ~clk;

  addcell_seq i_addcell_seq (.*);

  int checks = 0, fails = 0;
  int ca, cb, dep_wait = 0, dep_rem = 0, cal_cnt = 0;
  int wr_cnt, cout_cnt, codes[3];
  bit mute = 0, extra = 0, spike_next = 0, got = 0, order_ok = 1;
  bit cal_seen = 0, clr_seen = 0;
  bit cin_at_cal = 0, cin_at_spike = 0, cin_at_copy = 0;
  bit hold_prev = 0, rand_ready = 0;
  logic [3:0] prev_data;
  logic prev_cout, prev_err;
  int res_sum, res_cout, res_err, carry_over = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sum(input int a, input int b, input int c);
    return (a + b + c) % 16;
  endfunction
  function automatic int exp_cout(input int a, input int b, input int c);
    return (a + b + c) >= 16 ? 1 : 0;
  endfunction

  // Behavioural capacitor, comparator, DAC, calibration and copy model.
  initial begin
    forever begin
      @(negedge clk);
      cmp_spike = 1'b0; dac_ack = 1'b0; copy_ack = 1'b0; cal_done = 1'b0; cin_pulse = 1'b0;
      if (!rst_n) continue;
      if (cout_pulse) cout_cnt++;
      if (hold_prev) begin
        chk(sum_valid && sum_data == prev_data && sum_cout == prev_cout && sum_err == prev_err,
            "R12 result held under back-pressure", sum_data, prev_data);
      end
      if (dis_a && dis_b && cal_seen) clr_seen = 1;
      if (dis_a) ca = 0;
      if (dis_b) cb = 0;
      if (spike_next) begin
        spike_next = 0;
        cmp_spike = 1'b1;
      end
      if (cal_req) begin
        cal_seen = 1;
        if (cin_at_cal) begin cin_pulse = 1'b1; cin_at_cal = 0; end
        cal_cnt++;
        if (cal_cnt == 3) begin cal_done = 1'b1; cal_cnt = 0; end
      end
      if (dep_wait > 0) begin
        dep_wait--;
        if (dep_wait == 0) begin
          if (steer_b) cb += dep_rem; else ca += dep_rem;
          if (extra) begin cmp_spike = 1'b1; extra = 0; end
          dac_ack = 1'b1;
        end
      end else if (dac_req) begin
        if (!clr_seen) order_ok = 0;
        if (cmp_sel) order_ok = 0;
        if (wr_cnt < 3) codes[wr_cnt] = int'(dac_code);
        wr_cnt++;
        if (!steer_b && ca + int'(dac_code) >= 16) begin
          dep_rem = ca + int'(dac_code) - 16;
          ca = 16;
          if (!mute) begin
            cmp_spike = 1'b1;
            if (cin_at_spike) begin cin_pulse = 1'b1; cin_at_spike = 0; end
          end
          dep_wait = 2;
        end else begin
          if (steer_b) cb += int'(dac_code); else ca += int'(dac_code);
          dac_ack = 1'b1;
        end
      end
      if (copy_req) begin
        ca += cb;
        copy_ack = 1'b1;
        if (cin_at_copy) begin cin_pulse = 1'b1; cin_at_copy = 0; end
      end
      if (lsb_step) begin
        if (!cmp_sel) order_ok = 0;
        cb++;
        if (cb > ca && !mute) spike_next = 1;
      end
      sum_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
      hold_prev = sum_valid && !sum_ready;
      prev_data = sum_data; prev_cout = sum_cout; prev_err = sum_err;
      if (sum_valid && sum_ready) begin
        res_sum = int'(sum_data); res_cout = int'(sum_cout); res_err = int'(sum_err);
        got = 1;
      end
    end
  end

  // mode: 0 none, 1 pulse during calibration, 2 pulse with overflow spike, 3 late pulse in copy
  task automatic run(input int a, input int b, input int mode, input bit mute_i, input bit extra_i);
    int cin_eff, nwr;
    cin_eff = (carry_over != 0 || mode == 1 || (mode == 2 && a + b >= 16)) ? 1 : 0;
    carry_over = (mode == 3) ? 1 : 0;
    @(negedge clk);
    ca = int'($urandom % 8) + 1; cb = int'($urandom % 8) + 1;
    wr_cnt = 0; cout_cnt = 0; got = 0; order_ok = 1; cal_seen = 0; clr_seen = 0;
    mute = mute_i; extra = extra_i;
    cin_at_cal = (mode == 1); cin_at_spike = (mode == 2 && a + b >= 16); cin_at_copy = (mode == 3);
    op_a = 4'(a); op_b = 4'(b); op_valid = 1'b1;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(!op_ready, "R1 op_ready low while busy", op_ready, 0);
    while (!got) @(negedge clk);
    @(negedge clk);
    if (mute_i) begin
      chk(res_sum == 15, "R11 saturated sum", res_sum, 15);
      chk(res_err == 1, "R11 error flag", res_err, 1);
    end else begin
      chk(res_sum == exp_sum(a, b, cin_eff), "R10 R8 R13 sum", res_sum, exp_sum(a, b, cin_eff));
      chk(res_cout == exp_cout(a, b, cin_eff), "R12 R13 cout status", res_cout, exp_cout(a, b, cin_eff));
      chk(res_err == 0, "R10 no error", res_err, 0);
      chk(cout_cnt == exp_cout(a, b, cin_eff), "R6 R7 cout pulse count", cout_cnt, exp_cout(a, b, cin_eff));
    end
    nwr = 2 + cin_eff;
    chk(wr_cnt == nwr, "R5 R4 DAC write count", wr_cnt, nwr);
    chk(codes[0] == a && codes[1] == b, "R3 operand codes", codes[0] * 16 + codes[1], a * 16 + b);
    if (cin_eff != 0) chk(codes[2] == 1, "R3 carry code", codes[2], 1);
    chk(order_ok, "R2 R9 phase order and comparator select", order_ok, 1);
    mute = 0; extra = 0; cin_at_cal = 0; cin_at_spike = 0; cin_at_copy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready && !sum_valid && !dac_req && !cal_req && !cout_pulse, "R1 reset state", op_ready, 1);
    // R13 directed example: 1010 + 1010 + 1 -> 0101 with carry
    run(10, 10, 1, 0, 0);
    // R4 late carry-in lands in the next addition
    run(2, 3, 3, 0, 0);
    run(4, 4, 0, 0, 0);
    // R7 extra spike after overflow is ignored
    run(12, 9, 0, 0, 1);
    // coincident spike and carry-in
    run(15, 15, 2, 0, 0);
    run(8, 7, 1, 0, 0);
    // R11 mute comparator
    run(3, 4, 0, 1, 0);
    run(0, 0, 0, 0, 0);
    run(15, 0, 0, 0, 0);
    // R13 all 512 combinations, random carry-in timing and back-pressure
    rand_ready = 1;
    for (int i = 0; i < 512; i++) begin
      int a, b, m;
      a = i % 16; b = (i / 16) % 16;
      if (i / 256 == 0) m = 0;
      else if (a + b >= 16 && ($urandom % 2) == 1) m = 2;
      else m = 1;
      run(a, b, m, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule